// File: doc/BRIEF.md
# SD/MMC Card Clock Stop Controller

This block sits beside the clock divider of an SD/MMC host. On every base-clock cycle it decides whether the card clock should run or be held. It drives a clock-enable and a matching held flag. There are two reasons to stop the clock.

The first is idleness. When idle stopping is enabled, each command completion starts a countdown of a programmable number of cycles. The clock is gated when the countdown expires. The stop is postponed while the card reports busy, and it is applied on the first cycle the card is no longer busy.

The second is flow control. When the data buffer overflows or underflows, the clock is stopped. The stop happens either at once or only at a data block boundary, as a policy input selects. The clock restarts when the buffer condition clears. A new command request cancels any idle countdown and lifts an idle stop.

All inputs are plain control and status levels or one-cycle strobes. There is no streamed data interface, so the block applies no valid/ready back-pressure. It only produces the gate that the clock generator obeys.

Top module: `sd_clk_gate`

## Requirements
- R1: While `idle_stop_en` is 0, a `cmd_done` strobe never lowers `card_clk_en`.
- R2: With `idle_stop_en` at 1 and idle delay D (7 bits, 0 to 127), a `cmd_done` sampled at clock edge E with the card not busy lowers `card_clk_en` right after edge E+D. For D = 0 the clock is lowered right after edge E.
- R3: After reset, `card_clk_en` is 1, `card_clk_held` is 0 and the idle delay is 16.
- R4: While `card_busy` is high, the idle stop is held off. The clock is lowered after the first edge at or after E+D that samples `card_busy` low.
- R5: A write of the idle delay (`dly_wr` high) takes effect only when `idle_stop_en` is 0 at that edge. A write made while `idle_stop_en` is 1 leaves the delay unchanged.
- R6: With `blk_safe_stop` at 0, an edge that samples `buf_stall` high lowers `card_clk_en` right after that edge, even in the middle of a block.
- R7: With `blk_safe_stop` at 1, `buf_stall` sampled while `blk_busy` is 1 and `blk_last` is 0 does not stop the clock. The stop is applied after the first edge that samples `buf_stall` high together with either `blk_last` high or `blk_busy` low.
- R8: A flow-control stop is released right after the first edge that samples `buf_stall` low.
- R9: An edge that samples `cmd_issue` high, or `idle_stop_en` low, cancels any idle countdown and lifts any idle stop. `card_clk_en` is then 1 after that edge unless a flow-control stop is active. `cmd_issue` takes priority over `cmd_done` in the same cycle.
- R10: `card_clk_held` is the inverse of `card_clk_en` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock of the card clock generator |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_stop_en | input | 1 | Enables the automatic stop after each command |
| dly_wr | input | 1 | Write strobe for the idle delay |
| dly_wdata | input | 7 | New idle delay in cycles |
| blk_safe_stop | input | 1 | 1: flow-control stops wait for a block boundary |
| cmd_issue | input | 1 | Strobe: a new command is requested |
| cmd_done | input | 1 | Strobe: the current command completed |
| card_busy | input | 1 | Card busy level |
| buf_stall | input | 1 | Data buffer overflow/underflow level |
| blk_busy | input | 1 | High while a data block is being transferred |
| blk_last | input | 1 | Strobe on the final cycle of a data block |
| card_clk_en | output | 1 | 1: the card clock runs |
| card_clk_held | output | 1 | 1: the card clock is currently held |

## Verification
Every result is registered once, so each stimulus sampled at edge k shows up at the outputs just after edge k. The idle stop is the exception: it shows up D edges after the completion edge, or later if busy holds it off. The bench drives inputs at the falling edge and samples one time unit after the rising edge. For each delay value, it counts how many sampled edges, from the completion edge on, still see the clock enabled, and compares that count with D. The busy and block-boundary cases compare the cycle of the stop with the edge at which the releasing condition was sampled.

// File: rtl/sd_clk_gate_pkg.sv
package sd_clk_gate_pkg;
  localparam int unsigned DLY_W   = 7;
  localparam int unsigned DLY_RST = 16;

  typedef enum logic [1:0] {
    IDLE_RUN   = 2'd0,
    IDLE_COUNT = 2'd1,
    IDLE_HALT  = 2'd2
  } idle_state_e;
endpackage

// File: rtl/sd_clk_dly_reg.sv
module sd_clk_dly_reg #(
  parameter int unsigned W   = 7,
  parameter int unsigned RST = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lock,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dly
);
  localparam logic [W-1:0] RST_V = W'(RST);

  // The delay may only be reloaded while the idle stop is disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dly <= RST_V;
    else if (wr && !lock)  dly <= wdata;
  end
endmodule

// File: rtl/sd_clk_idle_timer.sv
module sd_clk_idle_timer
  import sd_clk_gate_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] dly,
  input  logic         issue,
  input  logic         done,
  input  logic         busy,
  output logic         stop
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  idle_state_e st_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= IDLE_RUN;
      cnt_q <= ZERO;
    end else if (!en || issue) begin
      st_q  <= IDLE_RUN;
      cnt_q <= ZERO;
    end else if (done) begin
      if (dly == ZERO && !busy) begin
        st_q <= IDLE_HALT;
      end else begin
        st_q  <= IDLE_COUNT;
        cnt_q <= (dly == ZERO) ? ZERO : dly - ONE;
      end
    end else if (st_q == IDLE_COUNT) begin
      if (cnt_q != ZERO)  cnt_q <= cnt_q - ONE;
      else if (!busy)     st_q  <= IDLE_HALT;
    end
  end

  assign stop = (st_q == IDLE_HALT);
endmodule

// File: rtl/sd_clk_flow_stop.sv
module sd_clk_flow_stop (
  input  logic clk,
  input  logic rst_n,
  input  logic safe,
  input  logic stall,
  input  logic blk_busy,
  input  logic blk_last,
  output logic stop
);
  logic at_boundary;
  assign at_boundary = !blk_busy || blk_last;

  // Once stopped, the stop is held for as long as the stall persists.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop <= 1'b0;
    else        stop <= stall && (stop || !safe || at_boundary);
  end
endmodule

// File: rtl/sd_clk_gate.sv
module sd_clk_gate
  import sd_clk_gate_pkg::*;
#(
  parameter int unsigned DW  = DLY_W,
  parameter int unsigned DRV = DLY_RST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_stop_en,
  input  logic          dly_wr,
  input  logic [DW-1:0] dly_wdata,
  input  logic          blk_safe_stop,
  input  logic          cmd_issue,
  input  logic          cmd_done,
  input  logic          card_busy,
  input  logic          buf_stall,
  input  logic          blk_busy,
  input  logic          blk_last,
  output logic          card_clk_en,
  output logic          card_clk_held
);
  logic [DW-1:0] dly_q;
  logic          idle_stop;
  logic          flow_stop;

  sd_clk_dly_reg #(.W(DW), .RST(DRV)) u_dly (
    .clk(clk), .rst_n(rst_n), .lock(idle_stop_en),
    .wr(dly_wr), .wdata(dly_wdata), .dly(dly_q)
  );

  sd_clk_idle_timer #(.W(DW)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(idle_stop_en), .dly(dly_q),
    .issue(cmd_issue), .done(cmd_done), .busy(card_busy), .stop(idle_stop)
  );

  sd_clk_flow_stop u_flow (
    .clk(clk), .rst_n(rst_n), .safe(blk_safe_stop), .stall(buf_stall),
    .blk_busy(blk_busy), .blk_last(blk_last), .stop(flow_stop)
  );

  assign card_clk_en   = !(idle_stop || flow_stop);
  assign card_clk_held = idle_stop || flow_stop;
endmodule

// File: rtl/sd_clk_gate_chk.sv
module sd_clk_gate_chk #(
  parameter int unsigned DW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle_stop_en,
  input logic          dly_wr,
  input logic          blk_safe_stop,
  input logic          cmd_issue,
  input logic          card_busy,
  input logic          buf_stall,
  input logic          blk_busy,
  input logic          blk_last,
  input logic          card_clk_en,
  input logic          card_clk_held,
  input logic [DW-1:0] dly_q,
  input logic          flow_stop
);
  assert_disabled_runs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_stop_en && !buf_stall) |=> card_clk_en);

  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (card_busy && card_clk_en && !buf_stall) |=> card_clk_en);

  assert_dly_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_wr && idle_stop_en) |=> $stable(dly_q));

  assert_any_cycle_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_safe_stop && buf_stall) |=> !card_clk_en);

  assert_mid_block_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_safe_stop && blk_busy && !blk_last && !flow_stop) |=> !flow_stop);

  assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_stall |=> !flow_stop);

  assert_issue_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && !buf_stall) |=> card_clk_en);

  assert_held_inverse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    card_clk_held != card_clk_en);
endmodule

bind sd_clk_gate sd_clk_gate_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_stop_en(idle_stop_en), .dly_wr(dly_wr),
  .blk_safe_stop(blk_safe_stop), .cmd_issue(cmd_issue), .card_busy(card_busy),
  .buf_stall(buf_stall), .blk_busy(blk_busy), .blk_last(blk_last),
  .card_clk_en(card_clk_en), .card_clk_held(card_clk_held),
  .dly_q(dly_q), .flow_stop(flow_stop)
);

// File: tb/sd_clk_gate_bench.sv
module sd_clk_gate_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_stop_en = 0, dly_wr = 0, blk_safe_stop = 0, cmd_issue = 0;
  logic cmd_done = 0, card_busy = 0, buf_stall = 0, blk_busy = 0, blk_last = 0;
  logic [6:0] dly_wdata = '0;
  logic card_clk_en, card_clk_held;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_clk_gate u_sd_clk_gate (
    .clk(clk), .rst_n(rst_n), .idle_stop_en(idle_stop_en), .dly_wr(dly_wr),
    .dly_wdata(dly_wdata), .blk_safe_stop(blk_safe_stop), .cmd_issue(cmd_issue),
    .cmd_done(cmd_done), .card_busy(card_busy), .buf_stall(buf_stall),
    .blk_busy(blk_busy), .blk_last(blk_last),
    .card_clk_en(card_clk_en), .card_clk_held(card_clk_held)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    chk("R10 held", int'(card_clk_held), int'(!card_clk_en));
  endtask

  task automatic write_dly(input int d);
    @(negedge clk); dly_wr = 1; dly_wdata = 7'(d);
    @(negedge clk); dly_wr = 0;
  endtask

  task automatic restart();
    @(negedge clk); cmd_issue = 1;
    tick();
    cmd_issue = 0;
  endtask

  // Pulses cmd_done, then counts sampled edges (completion edge included)
  // that still see the clock running.
  task automatic run_idle(output int n);
    @(negedge clk); cmd_done = 1;
    n = 0;
    for (int k = 0; k < 400; k++) begin
      tick();
      cmd_done = 0;
      if (!card_clk_en) break;
      n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    chk("R3 reset clk_en", int'(card_clk_en), 1);
    chk("R3 reset held", int'(card_clk_held), 0);
    @(negedge clk); rst_n = 1;

    // R1: disabled idle stop
    run_idle(n);
    chk("R1 no idle stop", n, 400);

    // R3 default delay, R5 write ignored while enabled
    @(negedge clk); idle_stop_en = 1;
    write_dly(3);
    run_idle(n);
    chk("R3/R5 default delay 16 kept", n, 16);
    restart();
    chk("R9 restart after stop", int'(card_clk_en), 1);

    // R2 exhaustive delay sweep
    for (int d = 0; d < 128; d++) begin
      @(negedge clk); idle_stop_en = 0;
      write_dly(d);
      @(negedge clk); idle_stop_en = 1;
      run_idle(n);
      chk($sformatf("R2 delay %0d", d), n, d);
      restart();
    end

    // R9 cmd_issue cancels countdown (delay is 127)
    @(negedge clk); cmd_done = 1;
    tick(); cmd_done = 0;
    repeat (10) tick();
    restart();
    n = 0;
    for (int k = 0; k < 200; k++) begin tick(); if (card_clk_en) n++; end
    chk("R9 countdown cancelled", n, 200);

    // R4 busy during countdown, delay 10
    @(negedge clk); idle_stop_en = 0; write_dly(10);
    @(negedge clk); idle_stop_en = 1; cmd_done = 1;
    tick(); cmd_done = 0;
    repeat (3) tick();
    @(negedge clk); card_busy = 1;
    n = 0;
    for (int k = 0; k < 25; k++) begin tick(); if (card_clk_en) n++; end
    chk("R4 held while busy", n, 25);
    @(negedge clk); card_busy = 0;
    tick();
    chk("R4 stop on busy release", int'(card_clk_en), 0);
    restart();

    // R4 busy at completion, delay 0
    @(negedge clk); idle_stop_en = 0; write_dly(0);
    @(negedge clk); idle_stop_en = 1; card_busy = 1; cmd_done = 1;
    tick(); cmd_done = 0;
    repeat (4) tick();
    chk("R4 busy delay 0 held", int'(card_clk_en), 1);
    @(negedge clk); card_busy = 0;
    tick();
    chk("R4 busy delay 0 stop", int'(card_clk_en), 0);
    restart();
    @(negedge clk); idle_stop_en = 0;
    tick();
    chk("R9 disable runs", int'(card_clk_en), 1);

    // R6 policy 0: mid-block stall stops at once
    @(negedge clk); blk_busy = 1; buf_stall = 1;
    tick();
    chk("R6 immediate stop", int'(card_clk_en), 0);
    @(negedge clk); buf_stall = 0;
    tick();
    chk("R8 resume", int'(card_clk_en), 1);

    // R7 policy 1: deferred to block end
    @(negedge clk); blk_safe_stop = 1; buf_stall = 1;
    n = 0;
    for (int k = 0; k < 5; k++) begin tick(); if (card_clk_en) n++; end
    chk("R7 no stop mid-block", n, 5);
    @(negedge clk); blk_last = 1;
    tick();
    chk("R7 stop at block end", int'(card_clk_en), 0);
    @(negedge clk); blk_last = 0; blk_busy = 0;
    repeat (3) tick();
    chk("R8 held while stalled", int'(card_clk_en), 0);
    @(negedge clk); buf_stall = 0;
    tick();
    chk("R8 resume policy 1", int'(card_clk_en), 1);
    @(negedge clk); buf_stall = 1;
    tick();
    chk("R7 stop outside block", int'(card_clk_en), 0);
    @(negedge clk); buf_stall = 0;
    tick();

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule